// File: doc/BRIEF.md
# Battery Thermistor Zone Classifier

This block turns a stream of sampled 8-bit thermistor voltage codes into a battery temperature zone and into the charge-control signals that follow from it. The thermistor is an NTC part biased from a fixed source, so a larger code means a colder battery; all comparisons run in that inverted sense. Five programmable limits (open, cold, cool, warm, hot) set the zone edges, and a small control register picks the policy, the warm-zone voltage reduction and whether the function is active at all.

While the input supply is present, conversions are only accepted inside a duty-cycled window (25 of every 225 cycles by default), which the block generates and exports so the converter can bias the thermistor only when needed. Without the supply every strobe is accepted. A zone is adopted only when two consecutive accepted samples classify the same way, so noise at a limit does not make the outputs chatter. An over-range reading is taken as a missing thermistor and pauses charging until it clears.

Top module: `ts_zone_ctrl`

## Requirements
- R1: After reset the limits are cold 0x7C, cool 0x6D, warm 0x38, hot 0x27, open 0xE6; the control register holds function enabled, custom policy, warm reduction code 011; outputs are zone 0, charge enable 1, current reduction 0, voltage reduction 0, open flag 0, sample window 1.
- R2: A sample is classified in this precedence: code > open gives OPEN (zone 5); else code >= cold gives COLD (4); else code <= hot gives HOT (3); else code >= cool gives COOL (2); else code <= warm gives WARM (1); else NORMAL (0).
- R3: The zone changes only when two consecutive accepted samples give the same class; it takes that class on the edge of the second sample, and all control outputs follow one cycle later.
- R4: With the supply absent the sample window is 1; after the supply rises the window is 1 for the first WIN_ON of every WIN_PERIOD cycles, counting the first present edge as cycle 1 (so it falls after edge 25 and returns after edge 225); a strobe outside the window is ignored.
- R5: Custom policy (control bit 1 = 0): HOT disables charging; COLD and COOL keep charging with current reduction 1 (current taken from the thermistor current setting); WARM keeps full current with the warm voltage reduction applied; NORMAL gives full charging.
- R6: Hot/cold-only policy (control bit 1 = 1): HOT and COLD disable charging; COOL and WARM behave like NORMAL, with no reduction of current or voltage; the zone output still reports the class.
- R7: The warm voltage reduction is control bits [4:2], one step per 50 mV; codes 000 to 110 are output unchanged, 111 is limited to 110.
- R8: In the OPEN zone charging is disabled and the open flag is 1 in both policies, until two non-open samples are accepted.
- R9: With control bit 0 = 0 the function is off: charge enable 1, current reduction 0, voltage reduction 0, open flag 0, zone 0, whatever the samples.
- R10: A write at address 0..5 loads cold, cool, warm, hot, open and control respectively (control from data bits [4:0]); writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| supply_present | input | 1 | Input supply valid |
| sample_valid | input | 1 | Thermistor code strobe |
| ts_code | input | 8 | Sampled thermistor voltage code |
| sample_window | output | 1 | Sampling window / bias request |
| chg_enable | output | 1 | Charging permitted |
| cur_reduce | output | 1 | Use the thermistor charge-current setting |
| vreg_drop | output | 3 | Regulation voltage reduction, 50 mV per step |
| zone | output | 3 | Reported zone code |
| ts_open | output | 1 | Thermistor open condition |

## Verification
A register write lands on its clock edge and reaches the control outputs one edge later; a pair of agreeing samples moves the zone on the second sample's edge and the control outputs one edge after that, so every check is taken at the falling edge following that third edge. The window follows the count of edges since the supply rose, and the bench keeps its own edge count to compare the window at the 24th, 25th, 224th and 225th edges. Single samples and samples outside the window are each followed by a check that the zone and outputs are unchanged.

// File: rtl/tsz_pkg.sv
package tsz_pkg;
  typedef enum logic [2:0] {
    ZN_NORMAL = 3'd0,
    ZN_WARM   = 3'd1,
    ZN_COOL   = 3'd2,
    ZN_HOT    = 3'd3,
    ZN_COLD   = 3'd4,
    ZN_OPEN   = 3'd5
  } zone_e;

  localparam int DROP_W = 3;
  localparam logic [DROP_W-1:0] DROP_MAX = 3'd6;

  // Limit register indices, equal to their write addresses.
  localparam int IDX_COLD = 0;
  localparam int IDX_COOL = 1;
  localparam int IDX_WARM = 2;
  localparam int IDX_HOT  = 3;
  localparam int IDX_OPEN = 4;
  localparam int NUM_THR  = 5;
  localparam int ADDR_CTRL = 5;

  typedef struct packed {
    logic [DROP_W-1:0] warm_drop;
    logic              strict_mode;
    logic              ts_en;
  } ctrl_t;
endpackage

// File: rtl/tsz_regs.sv
module tsz_regs
  import tsz_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int ADDR_W = 3,
  parameter logic [CODE_W-1:0] RST_COLD = 8'h7C,
  parameter logic [CODE_W-1:0] RST_COOL = 8'h6D,
  parameter logic [CODE_W-1:0] RST_WARM = 8'h38,
  parameter logic [CODE_W-1:0] RST_HOT  = 8'h27,
  parameter logic [CODE_W-1:0] RST_OPEN = 8'hE6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] thr_o [NUM_THR],
  output ctrl_t             ctrl_o
);
  localparam int CTRL_W = $bits(ctrl_t);
  localparam logic [CODE_W-1:0] RST_VAL [NUM_THR] =
    '{RST_COLD, RST_COOL, RST_WARM, RST_HOT, RST_OPEN};

  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) thr_o[i] <= RST_VAL[i];
      else if (wr_en && wr_addr == ADDR_W'(i)) thr_o[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_o <= '{warm_drop: 3'b011, strict_mode: 1'b0, ts_en: 1'b1};
    else if (wr_en && wr_addr == ADDR_W'(ADDR_CTRL)) ctrl_o <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == ADDR_W'(ADDR_CTRL)) |=> $stable(ctrl_o)); // R10
endmodule

// File: rtl/tsz_window.sv
module tsz_window #(
  parameter int WIN_ON     = 25,
  parameter int WIN_PERIOD = 225
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_present,
  output logic window_o
);
  localparam int CNT_W = $clog2(WIN_PERIOD);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (!supply_present) cnt_nxt = '0;
    else if (cnt_q == CNT_W'(WIN_PERIOD - 1)) cnt_nxt = '0;
    else cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      window_o <= 1'b1;
    end else begin
      cnt_q    <= cnt_nxt;
      window_o <= !supply_present || (cnt_nxt < CNT_W'(WIN_ON));
    end
  end

  AST_OPEN_NO_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    !supply_present |=> window_o); // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(WIN_PERIOD)); // R4
endmodule

// File: rtl/tsz_classify.sv
module tsz_classify
  import tsz_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] thr [NUM_THR],
  output zone_e             zone_o
);
  zone_e cls, last_q;
  logic  have_q;

  always_comb begin
    if (code > thr[IDX_OPEN])       cls = ZN_OPEN;
    else if (code >= thr[IDX_COLD]) cls = ZN_COLD;
    else if (code <= thr[IDX_HOT])  cls = ZN_HOT;
    else if (code >= thr[IDX_COOL]) cls = ZN_COOL;
    else if (code <= thr[IDX_WARM]) cls = ZN_WARM;
    else                            cls = ZN_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zone_o <= ZN_NORMAL;
      last_q <= ZN_NORMAL;
      have_q <= 1'b0;
    end else if (accept) begin
      last_q <= cls;
      have_q <= 1'b1;
      if (have_q && cls == last_q) zone_o <= cls;
    end
  end

  AST_ZONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(zone_o)); // R3
  AST_FIRST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (accept && !have_q) |=> $stable(zone_o)); // R3
endmodule

// File: rtl/tsz_policy.sv
module tsz_policy
  import tsz_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  zone_e             zone_in,
  input  ctrl_t             ctrl,
  output logic              chg_enable,
  output logic              cur_reduce,
  output logic [DROP_W-1:0] vreg_drop,
  output logic [2:0]        zone_out,
  output logic              ts_open
);
  logic [DROP_W-1:0] drop_sat;
  logic              en_n, red_n, open_n;
  logic [DROP_W-1:0] drop_n;

  assign drop_sat = (ctrl.warm_drop > DROP_MAX) ? DROP_MAX : ctrl.warm_drop;

  always_comb begin
    en_n = 1'b1; red_n = 1'b0; drop_n = '0; open_n = 1'b0;
    case (zone_in)
      ZN_OPEN: begin en_n = 1'b0; open_n = 1'b1; end
      ZN_HOT:  en_n = 1'b0;
      ZN_COLD: begin
        if (ctrl.strict_mode) en_n = 1'b0;
        else red_n = 1'b1;
      end
      ZN_COOL: red_n = !ctrl.strict_mode;
      ZN_WARM: drop_n = ctrl.strict_mode ? '0 : drop_sat;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !ctrl.ts_en) begin
      chg_enable <= 1'b1;
      cur_reduce <= 1'b0;
      vreg_drop  <= '0;
      zone_out   <= ZN_NORMAL;
      ts_open    <= 1'b0;
    end else begin
      chg_enable <= en_n;
      cur_reduce <= red_n;
      vreg_drop  <= drop_n;
      zone_out   <= zone_in;
      ts_open    <= open_n;
    end
  end

  AST_HOT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (ctrl.ts_en && zone_in == ZN_HOT) |=> !chg_enable); // R5
  AST_OPEN_STOPS: assert property (@(posedge clk) disable iff (rst)
    ts_open |-> !chg_enable); // R8
  AST_DROP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    vreg_drop <= DROP_MAX); // R7
  AST_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
    !ctrl.ts_en |=> (chg_enable && !cur_reduce && !ts_open)); // R9
  AST_STRICT_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    ctrl.strict_mode |=> (vreg_drop == '0)); // R6
endmodule

// File: rtl/ts_zone_ctrl.sv
module ts_zone_ctrl
  import tsz_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int ADDR_W     = 3,
  parameter int WIN_ON     = 25,
  parameter int WIN_PERIOD = 225
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              supply_present,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] ts_code,
  output logic              sample_window,
  output logic              chg_enable,
  output logic              cur_reduce,
  output logic [2:0]        vreg_drop,
  output logic [2:0]        zone,
  output logic              ts_open
);
  logic [CODE_W-1:0] thr [NUM_THR];
  ctrl_t             ctrl;
  zone_e             zone_raw;
  logic              accept;

  tsz_regs #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .thr_o(thr), .ctrl_o(ctrl));

  tsz_window #(.WIN_ON(WIN_ON), .WIN_PERIOD(WIN_PERIOD)) u_win (
    .clk(clk), .rst(rst), .supply_present(supply_present),
    .window_o(sample_window));

  assign accept = sample_valid && sample_window;

  tsz_classify #(.CODE_W(CODE_W)) u_cls (
    .clk(clk), .rst(rst), .accept(accept), .code(ts_code),
    .thr(thr), .zone_o(zone_raw));

  tsz_policy u_pol (
    .clk(clk), .rst(rst), .zone_in(zone_raw), .ctrl(ctrl),
    .chg_enable(chg_enable), .cur_reduce(cur_reduce),
    .vreg_drop(vreg_drop), .zone_out(zone), .ts_open(ts_open));
endmodule

// File: tb/tb_ts_zone_ctrl.sv
module tb_ts_zone_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       supply_present = 1'b0;
  logic       sample_valid = 1'b0;
  logic [7:0] ts_code = '0;
  logic       sample_window, chg_enable, cur_reduce, ts_open;
  logic [2:0] vreg_drop, zone;

  int n_checks = 0;
  int n_fail   = 0;
  int kcnt     = 0;

  ts_zone_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .supply_present(supply_present), .sample_valid(sample_valid), .ts_code(ts_code),
    .sample_window(sample_window), .chg_enable(chg_enable), .cur_reduce(cur_reduce),
    .vreg_drop(vreg_drop), .zone(zone), .ts_open(ts_open));

  always #4 clk = ~clk;

  // fields: code[17:10] mode[9] zone[8:6] en[5] red[4] drop[3:1] open[0]
  localparam int NV = 18;
  localparam logic [17:0] VEC [NV] = '{
    {8'h80, 1'b0, 3'd4, 1'b1, 1'b1, 3'd0, 1'b0},
    {8'h7C, 1'b0, 3'd4, 1'b1, 1'b1, 3'd0, 1'b0},
    {8'h7B, 1'b0, 3'd2, 1'b1, 1'b1, 3'd0, 1'b0},
    {8'h6D, 1'b0, 3'd2, 1'b1, 1'b1, 3'd0, 1'b0},
    {8'h6C, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0},
    {8'h39, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0},
    {8'h38, 1'b0, 3'd1, 1'b1, 1'b0, 3'd3, 1'b0},
    {8'h28, 1'b0, 3'd1, 1'b1, 1'b0, 3'd3, 1'b0},
    {8'h27, 1'b0, 3'd3, 1'b0, 1'b0, 3'd0, 1'b0},
    {8'h05, 1'b0, 3'd3, 1'b0, 1'b0, 3'd0, 1'b0},
    {8'hE6, 1'b0, 3'd4, 1'b1, 1'b1, 3'd0, 1'b0},
    {8'hE7, 1'b0, 3'd5, 1'b0, 1'b0, 3'd0, 1'b1},
    {8'hFF, 1'b1, 3'd5, 1'b0, 1'b0, 3'd0, 1'b1},
    {8'h80, 1'b1, 3'd4, 1'b0, 1'b0, 3'd0, 1'b0},
    {8'h70, 1'b1, 3'd2, 1'b1, 1'b0, 3'd0, 1'b0},
    {8'h30, 1'b1, 3'd1, 1'b1, 1'b0, 3'd0, 1'b0},
    {8'h10, 1'b1, 3'd3, 1'b0, 1'b0, 3'd0, 1'b0},
    {8'h50, 1'b1, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    kcnt++;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  // two agreeing samples, then one edge for the outputs
  task automatic sample_pair(input logic [7:0] c);
    ts_code = c; sample_valid = 1'b1;
    tick();
    tick();
    sample_valid = 1'b0;
    tick();
  endtask

  task automatic sample_one(input logic [7:0] c);
    ts_code = c; sample_valid = 1'b1;
    tick();
    sample_valid = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 zone", zone, 0);
    check("R1 chg_enable", chg_enable, 1);
    check("R1 cur_reduce", cur_reduce, 0);
    check("R1 vreg_drop", vreg_drop, 0);
    check("R1 ts_open", ts_open, 0);
    check("R1 sample_window", sample_window, 1);

    // table: R2 classification, R5/R6 policy, R8 open
    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      reg_write(3'd5, {3'b000, 3'b011, v[9], 1'b1});
      sample_pair(v[17:10]);
      check("R2 zone", zone, int'(v[8:6]));
      check(v[9] ? "R6 chg_enable" : "R5 chg_enable", chg_enable, int'(v[5]));
      check(v[9] ? "R6 cur_reduce" : "R5 cur_reduce", cur_reduce, int'(v[4]));
      check(v[9] ? "R6 vreg_drop" : "R5 vreg_drop", vreg_drop, int'(v[3:1]));
      check("R8 ts_open", ts_open, int'(v[0]));
    end

    // R3 debounce: single or alternating samples do not move the zone
    reg_write(3'd5, 8'h0D);
    sample_one(8'h10);
    check("R3 single sample", zone, 0);
    sample_one(8'h60);
    sample_one(8'h10);
    check("R3 alternating", zone, 0);
    check("R3 chg held", chg_enable, 1);
    sample_one(8'h10);
    check("R3 pair hot zone", zone, 3);
    check("R3 pair hot chg", chg_enable, 0);

    // R9 function off
    reg_write(3'd5, 8'h0C);
    tick();
    check("R9 off zone", zone, 0);
    check("R9 off chg", chg_enable, 1);
    check("R9 off reduce", cur_reduce, 0);
    reg_write(3'd5, 8'h0D);
    tick();
    check("R9 back on zone", zone, 3);
    check("R9 back on chg", chg_enable, 0);
    sample_pair(8'hF8);
    reg_write(3'd5, 8'h0C);
    tick();
    check("R9 off open flag", ts_open, 0);
    check("R9 off open chg", chg_enable, 1);

    // R7 warm reduction limit
    reg_write(3'd5, 8'h1D);
    sample_pair(8'h30);
    check("R7 code 111 limited", vreg_drop, 6);
    reg_write(3'd5, 8'h15);
    tick();
    check("R7 code 101", vreg_drop, 5);
    reg_write(3'd5, 8'h01);
    tick();
    check("R7 code 000", vreg_drop, 0);
    check("R7 warm zone", zone, 1);

    // R10 write port
    reg_write(3'd5, 8'h0D);
    reg_write(3'd3, 8'h50);
    sample_pair(8'h48);
    check("R10 hot limit write", zone, 3);
    reg_write(3'd6, 8'h00);
    reg_write(3'd7, 8'h00);
    sample_pair(8'h7C);
    check("R10 addr 6/7 ignored cold", zone, 4);
    sample_pair(8'hE7);
    check("R10 addr 6/7 ignored open", zone, 5);
    reg_write(3'd4, 8'hF0);
    sample_pair(8'hE7);
    check("R10 open limit write zone", zone, 4);
    check("R10 open limit write flag", ts_open, 0);
    reg_write(3'd3, 8'h27);
    sample_pair(8'h60);
    check("R10 restore normal", zone, 0);

    // R4 sampling window with supply present
    supply_present = 1'b1;
    kcnt = 0;
    while (kcnt < 24) tick();
    check("R4 window edge 24", sample_window, 1);
    tick();
    check("R4 window edge 25", sample_window, 0);
    while (kcnt < 30) tick();
    sample_pair(8'h10);
    check("R4 outside window ignored", zone, 0);
    check("R4 outside window chg", chg_enable, 1);
    while (kcnt < 224) tick();
    check("R4 window edge 224", sample_window, 0);
    tick();
    check("R4 window edge 225", sample_window, 1);
    sample_pair(8'h10);
    check("R4 inside window accepted", zone, 3);
    supply_present = 1'b0;
    tick();
    check("R4 supply removed", sample_window, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule